// File: doc/BRIEF.md
# Feed-Forward Arbiter PUF Delay Model

This block is a cycle-stepped, synthesizable stand-in for a multiplexer-chain arbiter PUF. Every stage has a top and a bottom path. Process variation is replaced by signed integer delay constants, given per stage for the straight setting and for the crossed setting. A launched edge is not timed in real time. Instead the block keeps a running difference, the top arrival minus the bottom arrival, and updates it for one stage per clock cycle. The final arbiter reports which path was faster.

Feed-forward arbiters can be switched on. Each one samples the difference after an intermediate tap stage, and its decision becomes the select of later stages in place of a challenge bit. A 3-bit configuration chooses the topology at each start:

- plain chain;
- overlapping spans;
- cascaded spans;
- separate spans.

Each feed-forward topology has a standard form, where one arbiter drives one stage. It also has a modified form, where one arbiter drives two consecutive stages. The chain grows so that all challenge bits are still consumed.

Top module: `puf_ff_arbiter_chain`

## Requirements
- R1: While reset is high, and in the cycle after it, `resp_o` and `done_o` are 0.
- R2: The difference D (top arrival minus bottom arrival) starts at 0 when a start is accepted. A straight stage s (select 0) sets D to D + straight[s]. A crossed stage (select 1) sets D to −D + cross[s]. `resp_o` is 1 when the final D is below 0, meaning the top edge arrived first.
- R3: A final D of exactly 0 (a tie) gives a response of 0.
- R4: A start accepted at edge E raises `done_o` at edge E+S, for exactly one cycle. S is the number of active stages: N for plain, N+M for standard feed-forward, N+2M for modified (N challenge bits, M feed-forward arbiters).
- R5: When a start is accepted, `resp_o` is cleared to 0. It changes again only together with `done_o`, and then holds until the next accepted start.
- R6: A start pulse while an evaluation is running is ignored. That evaluation's result and latency are unchanged.
- R7: Challenge bits are used in order from bit 0 upward. Each bit goes to the next stage, from stage 0 upward, that is not driven by a feed-forward arbiter.
- R8: Let W = 1 in standard form and W = 2 in modified form. Feed-forward arbiter k samples (D < 0) right after its tap stage t_k. It drives the selects of the W stages starting at t_k + W + 1.
- R9: In modified form (W = 2), one arbiter decision steers two consecutive stages.
- R10: The tap stages are as follows. Overlap: t_k = 1 + k·W. Cascade: t_k = 1 + 2k·W. Separate: t_k = 1 + k·(2W+1).
- R11: `cfg_i[1:0]` selects the topology: 0 plain, 1 overlap, 2 cascade, 3 separate. `cfg_i[2]` selects the modified form. Code 3'b100 is unused and behaves exactly as plain (code 0).
- R12: The challenge and configuration are captured at the accepted start. Later changes to `chal_i` and `cfg_i` do not affect the running evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; accepted only while idle |
| chal_i | input | N_CHAL | Challenge bits, bit 0 used first |
| cfg_i | input | 3 | Topology code and modified-form flag |
| resp_o | output | 1 | Registered response bit |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checker watches four things on every cycle:
- the done pulse lasts one cycle;
- the latency from an accepted start to done matches the mode chosen by the configuration, including the fallback code;
- the response changes only at done or at an accepted start;
- a start during an evaluation does not disturb the stage walk.

The response value itself, the tie rule, the order in which challenge bits are used, and the tap and destination positions of each topology can only be shown by the bench. It compares against its own stage-by-stage arithmetic model, using chosen delay constants. A second instance with all delays at zero forces ties.

// File: rtl/puf_ff_pkg.sv
package puf_ff_pkg;

  typedef enum logic [1:0] {
    TOPO_PLAIN    = 2'd0,
    TOPO_OVERLAP  = 2'd1,
    TOPO_CASCADE  = 2'd2,
    TOPO_SEPARATE = 2'd3
  } topo_e;

  typedef struct packed {
    topo_e topo;
    logic  modified;
  } ffcfg_t;

  // Code 3'b100 has no meaning and is folded onto the plain chain.
  function automatic ffcfg_t decode_cfg(input logic [2:0] code);
    ffcfg_t c;
    c.topo     = topo_e'(code[1:0]);
    c.modified = (code[1:0] == 2'd0) ? 1'b0 : code[2];
    return c;
  endfunction

  function automatic int span_width(input ffcfg_t c);
    return c.modified ? 2 : 1;
  endfunction

  // Stage after which feed-forward arbiter k samples the difference.
  function automatic int tap_stage(input ffcfg_t c, input int k);
    int w;
    w = span_width(c);
    case (c.topo)
      TOPO_OVERLAP:  return 1 + k * w;
      TOPO_CASCADE:  return 1 + 2 * k * w;
      TOPO_SEPARATE: return 1 + k * (2 * w + 1);
      default:       return 0;
    endcase
  endfunction

  // First stage whose select is driven by arbiter k.
  function automatic int dest_stage(input ffcfg_t c, input int k);
    return tap_stage(c, k) + span_width(c) + 1;
  endfunction

  function automatic int active_stages(input ffcfg_t c, input int n_chal, input int n_ff);
    if (c.topo == TOPO_PLAIN) return n_chal;
    return n_chal + span_width(c) * n_ff;
  endfunction

endpackage

// File: rtl/puf_ff_route.sv
module puf_ff_route
  import puf_ff_pkg::*;
#(
  parameter int N_FF  = 2,
  parameter int STG_W = 4,
  localparam int FFI_W = (N_FF > 1) ? $clog2(N_FF) : 1
) (
  input  ffcfg_t             cfg,
  input  logic [STG_W-1:0]   stage,
  output logic               is_ff,
  output logic [FFI_W-1:0]   ff_idx,
  output logic [N_FF-1:0]    tap_hit
);

  logic [N_FF-1:0] dest_hit;
  logic            ff_on;

  assign ff_on = (cfg.topo != TOPO_PLAIN);

  for (genvar k = 0; k < N_FF; k++) begin : g_path
    assign tap_hit[k]  = ff_on && (int'(stage) == tap_stage(cfg, k));
    assign dest_hit[k] = ff_on && (int'(stage) >= dest_stage(cfg, k)) &&
                         (int'(stage) < dest_stage(cfg, k) + span_width(cfg));
  end

  always_comb begin
    is_ff  = |dest_hit;
    ff_idx = '0;
    for (int k = 0; k < N_FF; k++) begin
      if (dest_hit[k]) ff_idx = FFI_W'(k);
    end
  end

endmodule

// File: rtl/puf_stage_delay.sv
module puf_stage_delay #(
  parameter int N_STG = 12,
  parameter int DW    = 8,
  parameter int STG_W = 4,
  parameter logic [N_STG*DW-1:0] STRAIGHT = '0,
  parameter logic [N_STG*DW-1:0] CROSS    = '0
) (
  input  logic [STG_W-1:0]     stage,
  input  logic                 sel,
  output logic signed [DW-1:0] delta
);

  logic signed [DW-1:0] st_a [N_STG];
  logic signed [DW-1:0] cr_a [N_STG];

  for (genvar s = 0; s < N_STG; s++) begin : g_stg
    assign st_a[s] = STRAIGHT[s*DW +: DW];
    assign cr_a[s] = CROSS[s*DW +: DW];
  end

  always_comb begin
    delta = '0;
    for (int s = 0; s < N_STG; s++) begin
      if (int'(stage) == s) delta = sel ? cr_a[s] : st_a[s];
    end
  end

endmodule

// File: rtl/puf_ff_arbiter_chain.sv
module puf_ff_arbiter_chain
  import puf_ff_pkg::*;
#(
  parameter int N_CHAL = 8,
  parameter int N_FF   = 2,
  parameter int DW     = 8,
  parameter logic [(N_CHAL+2*N_FF)*DW-1:0] DLY_STRAIGHT = 96'h05_FB_02_FE_06_FD_01_04_FC_03_FF_02,
  parameter logic [(N_CHAL+2*N_FF)*DW-1:0] DLY_CROSS    = 96'hFD_04_FA_02_01_FE_05_FC_03_FF_06_FB
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [N_CHAL-1:0] chal_i,
  input  logic [2:0]        cfg_i,
  output logic              resp_o,
  output logic              done_o
);

  localparam int N_STG = N_CHAL + 2 * N_FF;
  localparam int STG_W = $clog2(N_STG + 1);
  localparam int FFI_W = (N_FF > 1) ? $clog2(N_FF) : 1;
  localparam int ACC_W = DW + $clog2(N_STG) + 2;

  logic                    busy_q;
  logic [STG_W-1:0]        stage_q, last_q;
  logic [N_CHAL-1:0]       chal_q;
  ffcfg_t                  cfg_q;
  logic signed [ACC_W-1:0] diff_q;
  logic [N_FF-1:0]         ffbit_q;
  logic                    resp_q, done_q;

  logic                    is_ff;
  logic [FFI_W-1:0]        ff_idx;
  logic [N_FF-1:0]         tap_hit;
  logic                    sel;
  logic signed [DW-1:0]    delta;
  logic signed [ACC_W-1:0] delta_x, diff_nxt;
  logic                    top_wins;
  ffcfg_t                  cfg_new;

  puf_ff_route #(.N_FF(N_FF), .STG_W(STG_W)) route_i (
    .cfg     (cfg_q),
    .stage   (stage_q),
    .is_ff   (is_ff),
    .ff_idx  (ff_idx),
    .tap_hit (tap_hit)
  );

  // Straight or crossed select: feed-forward decision wins over the challenge.
  assign sel = is_ff ? ffbit_q[ff_idx] : chal_q[0];

  puf_stage_delay #(
    .N_STG(N_STG), .DW(DW), .STG_W(STG_W),
    .STRAIGHT(DLY_STRAIGHT), .CROSS(DLY_CROSS)
  ) delay_i (
    .stage (stage_q),
    .sel   (sel),
    .delta (delta)
  );

  assign delta_x  = ACC_W'(delta);
  assign diff_nxt = sel ? (delta_x - diff_q) : (diff_q + delta_x);
  assign top_wins = diff_nxt < 0;
  assign cfg_new  = decode_cfg(cfg_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q  <= 1'b0;
      stage_q <= '0;
      last_q  <= '0;
      chal_q  <= '0;
      cfg_q   <= '{topo: TOPO_PLAIN, modified: 1'b0};
      diff_q  <= '0;
      ffbit_q <= '0;
      resp_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          stage_q <= '0;
          chal_q  <= chal_i;
          cfg_q   <= cfg_new;
          last_q  <= STG_W'(active_stages(cfg_new, N_CHAL, N_FF) - 1);
          diff_q  <= '0;
          ffbit_q <= '0;
          resp_q  <= 1'b0;
        end
      end else begin
        diff_q  <= diff_nxt;
        stage_q <= stage_q + 1'b1;
        if (!is_ff) chal_q <= chal_q >> 1;
        for (int k = 0; k < N_FF; k++) begin
          if (tap_hit[k]) ffbit_q[k] <= top_wins;
        end
        if (stage_q == last_q) begin
          busy_q <= 1'b0;
          resp_q <= top_wins;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign resp_o = resp_q;
  assign done_o = done_q;

endmodule

// File: rtl/puf_ff_arbiter_chain_chk.sv
module puf_ff_arbiter_chain_chk #(
  parameter int N_CHAL = 8,
  parameter int N_FF   = 2,
  parameter int STG_W  = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic [2:0]       cfg_i,
  input logic             resp_o,
  input logic             done_o,
  input logic             busy_i,
  input logic [STG_W-1:0] stage_i
);

  logic [15:0] cnt_q, exp_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (start_i && !busy_i) begin
      cnt_q <= '0;
      exp_q <= (cfg_i[1:0] == 2'd0) ? 16'(N_CHAL) :
               (cfg_i[2] ? 16'(N_CHAL + 2 * N_FF) : 16'(N_CHAL + N_FF));
    end else if (busy_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);

  // R4
  latency_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (cnt_q == exp_q));

  // R5
  resp_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(resp_o) |-> (done_o || $past(start_i && !busy_i)));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_i && start_i) |=> (!busy_i || (stage_i == $past(stage_i) + 1'b1)));

endmodule

bind puf_ff_arbiter_chain puf_ff_arbiter_chain_chk #(
  .N_CHAL(N_CHAL), .N_FF(N_FF), .STG_W(STG_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .cfg_i   (cfg_i),
  .resp_o  (resp_o),
  .done_o  (done_o),
  .busy_i  (busy_q),
  .stage_i (stage_q)
);

// File: tb/puf_ff_arbiter_chain_tb_top.sv
`timescale 1ns/1ps
module puf_ff_arbiter_chain_tb_top;

  localparam int N  = 8;
  localparam int M  = 2;
  localparam int DW = 8;
  localparam int NS = N + 2 * M;
  // Stage s occupies bits [s*8 +: 8].
  localparam logic [NS*DW-1:0] ST = 96'h02FC07FD0102FA04FF05FE03;
  localparam logic [NS*DW-1:0] CR = 96'hFA05FD0104FE02FB03FF06FC;

  // {cfg, challenge, expected latency}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 8'h00, 4'd8},  {3'd0, 8'hFF, 4'd8},
    {3'd1, 8'h5A, 4'd10}, {3'd1, 8'hC3, 4'd10},
    {3'd2, 8'h5A, 4'd10}, {3'd2, 8'h0F, 4'd10},
    {3'd3, 8'h5A, 4'd10}, {3'd3, 8'h96, 4'd10},
    {3'd5, 8'h5A, 4'd12}, {3'd5, 8'h3C, 4'd12},
    {3'd6, 8'h5A, 4'd12}, {3'd6, 8'hE1, 4'd12},
    {3'd7, 8'h5A, 4'd12}, {3'd7, 8'h81, 4'd12},
    {3'd4, 8'h5A, 4'd8},  {3'd4, 8'h77, 4'd8}
  };

  logic         clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [N-1:0] chal = '0;
  logic [2:0]   cfg = '0;
  logic         resp, done, resp_z, done_z;

  always #10 clk = ~clk;

  puf_ff_arbiter_chain #(.N_CHAL(N), .N_FF(M), .DW(DW),
    .DLY_STRAIGHT(ST), .DLY_CROSS(CR)) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .chal_i(chal), .cfg_i(cfg),
    .resp_o(resp), .done_o(done));

  puf_ff_arbiter_chain #(.N_CHAL(N), .N_FF(M), .DW(DW),
    .DLY_STRAIGHT('0), .DLY_CROSS('0)) tie_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .chal_i(chal), .cfg_i(cfg),
    .resp_o(resp_z), .done_o(done_z));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int tap_of(input int topo, input int w, input int k);
    case (topo)
      1:       return 1 + k * w;
      2:       return 1 + 2 * k * w;
      3:       return 1 + k * (2 * w + 1);
      default: return 0;
    endcase
  endfunction

  function automatic logic ref_resp(input logic [2:0] code, input logic [N-1:0] ch);
    int topo, w, ns, d, ci, t;
    logic sel, isff;
    logic [M-1:0] ffb;
    topo = (code[1:0] == 2'd0) ? 0 : int'(code[1:0]);
    w    = (topo != 0 && code[2]) ? 2 : 1;
    ns   = (topo == 0) ? N : N + w * M;
    d = 0; ci = 0; ffb = '0;
    for (int s = 0; s < ns; s++) begin
      isff = 1'b0; sel = 1'b0;
      for (int k = 0; k < M; k++) begin
        t = tap_of(topo, w, k);
        if (topo != 0 && s >= t + w + 1 && s < t + 2 * w + 1) begin
          isff = 1'b1; sel = ffb[k];
        end
      end
      if (!isff) begin sel = ch[ci]; ci++; end
      if (sel) d = -d + int'($signed(CR[s*DW +: DW]));
      else     d = d + int'($signed(ST[s*DW +: DW]));
      for (int k = 0; k < M; k++) begin
        if (topo != 0 && s == tap_of(topo, w, k)) ffb[k] = (d < 0);
      end
    end
    return d < 0;
  endfunction

  logic got_resp, got_z;
  int   got_lat;
  bit   clr_ok, pulse_ok;

  task automatic run(input logic [2:0] c, input logic [N-1:0] ch, input int poke);
    @(negedge clk); cfg = c; chal = ch; start = 1'b1;
    @(negedge clk); start = 1'b0; clr_ok = (resp == 1'b0); got_lat = 0;
    if (poke > 0) begin cfg = 3'd3; chal = ~ch; end
    while (got_lat < 64) begin
      @(negedge clk);
      got_lat++;
      start = (poke > 0 && got_lat == poke);
      if (done) break;
    end
    start = 1'b0;
    got_resp = resp; got_z = resp_z;
    @(negedge clk);
    pulse_ok = !done;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic r;
    repeat (3) @(negedge clk);
    chk(resp == 1'b0, "R1 resp under reset", resp, 0);
    chk(done == 1'b0, "R1 done under reset", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(resp == 1'b0 && done == 1'b0, "R1 after reset", {resp, done}, 0);

    // R2 hand values: all straight sums to +6; stage 0 crossed ends at -1
    run(3'd0, 8'h00, 0);
    chk(got_resp == 1'b0, "R2 plain straight", got_resp, 0);
    run(3'd0, 8'h01, 0);
    chk(got_resp == 1'b1, "R2 plain stage0 crossed", got_resp, 1);
    chk(got_z == 1'b0, "R3 tie", got_z, 0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][14:12], VEC[i][11:4], 0);
      chk(got_resp == ref_resp(VEC[i][14:12], VEC[i][11:4]),
          "R7 R8 R9 R10 response", got_resp, ref_resp(VEC[i][14:12], VEC[i][11:4]));
      chk(got_lat == int'(VEC[i][3:0]), "R4 R11 latency", got_lat, VEC[i][3:0]);
      chk(clr_ok, "R5 cleared on start", 0, 1);
      chk(pulse_ok, "R4 single pulse", 0, 1);
      chk(got_z == 1'b0, "R3 tie gives 0", got_z, 0);
    end

    // R6 and R12: mid-run start pulse and scrambled inputs
    run(3'd6, 8'h5A, 3);
    chk(got_resp == ref_resp(3'd6, 8'h5A), "R6 R12 response", got_resp, ref_resp(3'd6, 8'h5A));
    chk(got_lat == 12, "R6 latency", got_lat, 12);

    // R5 hold after done
    r = got_resp;
    chal = 8'h33; cfg = 3'd2;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(resp == r && !done, "R5 hold", resp, r);
    end

    // R11 fallback code behaves as plain
    run(3'd4, 8'hA5, 0);
    chk(got_resp == ref_resp(3'd0, 8'hA5), "R11 fallback response", got_resp, ref_resp(3'd0, 8'hA5));
    chk(got_lat == N, "R11 fallback latency", got_lat, N);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule